// File: doc/BRIEF.md
# User Mask Control/Status Register

This block holds a six-bit user mask made of three control flags and two sticky status flags. The control flags select the byte order for memory accesses, enable the user performance monitors and force a fault on unaligned accesses. The two status flags record that a floating-point register in the low bank or in the high bank has been written. They stay set until software clears them.

Software changes the mask in one of three ways: it clears the bits selected by an operand, it sets the bits selected by an operand, or it writes the whole mask. The whole mask is always visible on an output for reading. Hardware reports up to two floating-point register writes per cycle, each given as a strobe and a 7-bit register index. Each write sets the status flag of its bank.

Top module: `umask_csr`

## Requirements
- R1: On a clock edge with `rst_n` low, every mask bit becomes 0.
- R2: Bit 0 always reads as 0, whatever the write, set or clear operations do.
- R3: An operation with `op_code` = 2'b11 (write) loads bits 5:1 of the mask from `op_data` on the next edge.
- R4: An operation with `op_code` = 2'b10 (set) ORs `op_data` into bits 5:1 and leaves the other bits unchanged.
- R5: An operation with `op_code` = 2'b01 (clear) clears each bit 5:1 that is set in `op_data` and leaves the other bits unchanged. `op_code` = 2'b00 changes nothing.
- R6: A floating-point write with index 0..31 (index bits 6:5 = 00) sets bit 4 on the next edge, and it stays set until software clears it.
- R7: A floating-point write with index 32..127 sets bit 5 on the next edge, and it stays set until software clears it.
- R8: When a hardware set of bit 4 or bit 5 falls in the same cycle as a software clear or write-to-0 of that bit, the bit ends up set.
- R9: Each of the two write ports sets its bank's flag independently, so two writes in one cycle can set both flags.
- R10: `big_endian`, `perf_mon_en` and `align_fault_en` equal mask bits 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 2 | 00 none, 01 clear, 10 set, 11 write |
| op_data | input | 6 | Mask operand or new mask value |
| fpw_valid | input | 2 | Floating-point write strobe per port |
| fpw_idx | input | 14 | Register index per port, 7 bits each, port 0 in bits 6:0 |
| mask | output | 6 | Current user mask |
| big_endian | output | 1 | Byte-order flag |
| perf_mon_en | output | 1 | Performance-monitor enable |
| align_fault_en | output | 1 | Unaligned-access fault enable |

## Verification
A software clear or full write can land in the same cycle as a floating-point write that sets the same status flag. The bench forces this case by issuing a clear of bits 4 and 5 together with writes to one or both banks. The result is judged against a behavioural model in which the hardware set wins. Dual-port writes that mix banks, and writes to the boundary indices 31 and 32, are also compared against the model on every clock.

// File: rtl/umask_pkg.sv
// Shared definitions for the user mask register.
// Assumes a six-bit mask with fixed bit positions, which consumers decode.
package umask_pkg;
    localparam int MASK_W  = 6;
    localparam int IDX_W   = 7;
    localparam int LOW_TOP = 31;  // highest index in the low bank

    localparam int BIT_BE  = 1;
    localparam int BIT_PM  = 2;
    localparam int BIT_AF  = 3;
    localparam int BIT_LOW = 4;
    localparam int BIT_HI  = 5;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_CLEAR = 2'b01,
        OP_SET   = 2'b10,
        OP_WRITE = 2'b11
    } umask_op_e;
endpackage

// File: rtl/umask_bank_detect.sv
// Turns the floating-point write ports into per-bank set requests.
// Assumes any index above LOW_TOP belongs to the high bank.
module umask_bank_detect #(
    parameter int PORTS   = 2,
    parameter int IDX_W   = 7,
    parameter int LOW_TOP = 31
) (
    input  logic [PORTS-1:0]       wr_valid,
    input  logic [PORTS*IDX_W-1:0] wr_idx,
    output logic                   hit_low,
    output logic                   hit_high
);
    logic [PORTS-1:0] low_v;
    logic [PORTS-1:0] high_v;

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        // classify this port's index against the bank boundary
        always_comb begin
            low_v[p]  = wr_valid[p] && (int'(wr_idx[p*IDX_W +: IDX_W]) <= LOW_TOP);
            high_v[p] = wr_valid[p] && (int'(wr_idx[p*IDX_W +: IDX_W]) >  LOW_TOP);
        end
    end

    // merge the per-port hits
    always_comb begin
        hit_low  = |low_v;
        hit_high = |high_v;
    end
endmodule

// File: rtl/umask_next.sv
// Computes the next mask from the software operation and hardware sets.
// A hardware set takes precedence over a software clear; bit 0 is forced to 0.
module umask_next
    import umask_pkg::*;
(
    input  logic [MASK_W-1:0] cur,
    input  logic [1:0]        op,
    input  logic [MASK_W-1:0] data,
    input  logic              hw_low,
    input  logic              hw_high,
    output logic [MASK_W-1:0] nxt
);
    logic [MASK_W-1:0] sw;
    logic [MASK_W-1:0] hw;

    // apply the software operation
    always_comb begin
        case (umask_op_e'(op))
            OP_CLEAR: sw = cur & ~data;
            OP_SET:   sw = cur | data;
            OP_WRITE: sw = data;
            default:  sw = cur;
        endcase
    end

    // overlay the hardware sticky sets and clear the reserved bit
    always_comb begin
        hw          = '0;
        hw[BIT_LOW] = hw_low;
        hw[BIT_HI]  = hw_high;
        nxt         = sw | hw;
        nxt[0]      = 1'b0;
    end
endmodule

// File: rtl/umask_csr.sv
// User mask register holding control flags and sticky floating-point status.
// Assumes a synchronous active-low reset; one software operation per cycle.
module umask_csr
    import umask_pkg::*;
#(
    parameter int FP_PORTS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                op_code,
    input  logic [MASK_W-1:0]         op_data,
    input  logic [FP_PORTS-1:0]       fpw_valid,
    input  logic [FP_PORTS*IDX_W-1:0] fpw_idx,
    output logic [MASK_W-1:0]         mask,
    output logic                      big_endian,
    output logic                      perf_mon_en,
    output logic                      align_fault_en
);
    logic              hit_low, hit_high;
    logic [MASK_W-1:0] nxt;
    logic [MASK_W-1:0] mask_q;

    umask_bank_detect #(.PORTS(FP_PORTS), .IDX_W(IDX_W), .LOW_TOP(LOW_TOP)) u_det (
        .wr_valid(fpw_valid), .wr_idx(fpw_idx),
        .hit_low(hit_low), .hit_high(hit_high)
    );

    umask_next u_nxt (
        .cur(mask_q), .op(op_code), .data(op_data),
        .hw_low(hit_low), .hw_high(hit_high), .nxt(nxt)
    );

    // hold the mask state
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= nxt;
    end

    // drive the outputs
    always_comb begin
        mask           = mask_q;
        big_endian     = mask_q[BIT_BE];
        perf_mon_en    = mask_q[BIT_PM];
        align_fault_en = mask_q[BIT_AF];
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> mask == '0);
    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) mask[0] == 1'b0);
    // R8
    low_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_low |=> mask[BIT_LOW]);
    // R8
    high_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_high |=> mask[BIT_HI]);
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 2'b00 && fpw_valid == '0) |=> $stable(mask));
    // R6
    low_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[BIT_LOW] && op_code != 2'b01 && op_code != 2'b11) |=> mask[BIT_LOW]);
endmodule

// File: tb/sim_umask_csr.sv
module sim_umask_csr;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  op_code = 0;
    logic [5:0]  op_data = 0;
    logic [1:0]  fpw_valid = 0;
    logic [13:0] fpw_idx = 0;
    logic [5:0]  mask;
    logic        big_endian, perf_mon_en, align_fault_en;

    int checks = 0, fails = 0;
    logic [5:0] model = 0;

    always #4 clk = ~clk;

    umask_csr u0 (.*);

    function automatic logic [5:0] ref_next(logic [5:0] m, logic rst, logic [1:0] op,
                                            logic [5:0] d, logic [1:0] v, logic [13:0] ix);
        logic [5:0] r;
        if (!rst) return 6'd0;
        r = m;
        if (op == 2'b01) r = r & ~d;
        else if (op == 2'b10) r = r | d;
        else if (op == 2'b11) r = d;
        for (int p = 0; p < 2; p++)
            if (v[p]) begin
                if (ix[p*7 +: 7] < 32) r[4] = 1'b1;
                else r[5] = 1'b1;
            end
        r[0] = 1'b0;
        return r;
    endfunction

    task automatic check(string req, logic [5:0] exp);
        checks++;
        if (mask !== exp) begin
            fails++;
            $display("FAIL %s mask=%b expected=%b", req, mask, exp);
        end
        checks++;
        if ({align_fault_en, perf_mon_en, big_endian} !== exp[3:1]) begin
            fails++;
            $display("FAIL R10 flags=%b expected=%b", {align_fault_en, perf_mon_en, big_endian}, exp[3:1]);
        end
    endtask

    task automatic step(string req, logic [1:0] op, logic [5:0] d,
                        logic [1:0] v, logic [6:0] i0, logic [6:0] i1);
        op_code = op; op_data = d; fpw_valid = v; fpw_idx = {i1, i0};
        model = ref_next(model, rst_n, op, d, v, {i1, i0});
        @(posedge clk); #2;
        check(req, model);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1;
        step("R1", 2'b11, 6'h3f, 2'b11, 7'd3, 7'd90);
        rst_n = 1;
        step("R2", 2'b11, 6'h3f, 0, 0, 0);
        step("R3", 2'b11, 6'b001010, 0, 0, 0);
        step("R4", 2'b10, 6'b000101, 0, 0, 0);
        step("R5", 2'b01, 6'b001011, 0, 0, 0);
        step("R5", 2'b00, 6'h3f, 0, 0, 0);
        step("R6", 2'b00, 0, 2'b01, 7'd31, 0);
        step("R6", 2'b10, 6'b000010, 0, 0, 0);
        step("R7", 2'b00, 0, 2'b10, 0, 7'd32);
        step("R7", 2'b01, 6'b001110, 0, 0, 0);
        step("R5", 2'b01, 6'b110000, 0, 0, 0);
        step("R9", 2'b00, 0, 2'b11, 7'd0, 7'd127);
        step("R8", 2'b01, 6'b110000, 2'b01, 7'd5, 0);
        step("R8", 2'b11, 6'b000000, 2'b10, 0, 7'd64);
        step("R8", 2'b01, 6'h3f, 2'b11, 7'd100, 7'd1);
        step("R9", 2'b01, 6'h3f, 2'b11, 7'd40, 7'd41);
        step("R9", 2'b11, 6'b000001, 2'b11, 7'd10, 7'd20);
        step("R2", 2'b10, 6'b000001, 0, 0, 0);
        for (int k = 0; k < 60; k++)
            step("R3", 2'((k * 7) % 4), 6'((k * 37) % 64), 2'(k % 4), 7'((k * 13) % 128), 7'((k * 29) % 128));
        rst_n = 0;
        step("R1", 2'b10, 6'h3f, 0, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule